// File: doc/BRIEF.md
# Multi-channel down-counting timer

A memory-mapped timer with a parameterised number of independent channels. Each channel holds a 64-bit interval and a 64-bit down-counter, both reached through pairs of 32-bit words. A channel advances on ticks from a shared power-of-two prescaler. When the counter steps from one to zero, the channel raises its status bit. After that it either reloads the interval and keeps running (periodic mode) or stops and drops its own enable (one-shot mode).

Software sets each channel up through a per-channel control word. The counter runs downward, so software that wants a rising time base inverts the low count word. A shared enable word and a shared status word feed one level interrupt. Status bits are cleared by writing ones to them. Turning a channel off is not immediate: the counter keeps advancing for a fixed number of clock cycles after the disabling write, and only then holds.

The register bus is synchronous, with address, write strobe, write data, read strobe and registered read data.

Top module: `mtimer_top`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq` is low.
- R2: The interrupt enable word is at offset 0x00 (bit n enables channel n) and the status word is at 0x04. Channel n uses these offsets from 0x20*n: control at +0x10, interval low at +0x14, interval high at +0x18, count low at +0x1C and count high at +0x20. Writes to any other offset change nothing, and reads from any other offset return zero.
- R3: The control word has run-enable at bit 0, load-request at bit 1, prescale code at bits 6:4 and one-shot select at bit 7 (1 = one-shot, 0 = periodic). A write with bits 0 and 1 both set copies the interval into the counter. The load-request bit always reads back 0.
- R4: A running counter drops by one on each prescaled tick, and prescale code p gives one tick every 2^p clock cycles.
- R5: The status bit of a channel is set on the edge where its counter steps from 1 to 0. In periodic mode the next tick reloads the interval, which gives a period of interval+1 ticks.
- R6: In one-shot mode, expiry leaves the counter at 0 and clears the channel's run-enable bit.
- R7: After a control write that clears run-enable, the counter still advances on that edge and on the next DIS_DELAY clock edges, then holds its value.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear reach the same bit on the same edge, the set wins.
- R9: `irq` is registered. It is high one cycle after any status bit and its enable bit are both 1, and low one cycle after no such pair exists.
- R10: Reading count low captures the counter's high half. A later read of count high returns that captured half, even if the counter has carried across the 32-bit boundary in the meantime.
- R11: `bus_rdata` carries the addressed word in the cycle after the edge that samples `bus_rd`. In a cycle after an edge without a read, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the timer source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with three channels and a disable delay of two cycles. With three channels, offset 0x70, where a fourth channel's control word would sit, is unmapped, while the top channel's count-high word at 0x60 is mapped. Random runs use prescale codes 0 to 2 with window lengths that are whole multiples of the tick period, so the expected count does not depend on the prescaler phase. Directed runs cover the 32-bit carry of the 64-bit counter, one-shot expiry with the interrupt path, and the exact length of the disable delay.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned OFF_IEN   = 'h00;
  localparam int unsigned OFF_IST   = 'h04;
  localparam int unsigned CH_STRIDE = 'h20;
  localparam int unsigned CH_CTL    = 'h10;
  localparam int unsigned CH_IVL    = 'h14;
  localparam int unsigned CH_IVH    = 'h18;
  localparam int unsigned CH_CNL    = 'h1C;
  localparam int unsigned CH_CNH    = 'h20;
  localparam int unsigned PRE_CODES = 8;
  localparam int unsigned CTL_EN      = 0;
  localparam int unsigned CTL_RL      = 1;
  localparam int unsigned CTL_PRE_LSB = 4;
  localparam int unsigned CTL_OS      = 7;
endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
  parameter int unsigned CODES = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CODES-1:0] tick_o
);
  localparam int unsigned DW = CODES - 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DW'(1);
  end

  // code p ticks when the low p bits of the free counter are all ones
  for (genvar p = 0; p < CODES; p++) begin : g_tick
    if (p == 0) begin : g_full
      assign tick_o[p] = 1'b1;
    end else begin : g_div
      assign tick_o[p] = &div_q[p-1:0];
    end
  end
endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIS_DELAY = 2,
  parameter int unsigned CODES     = 8,
  localparam int unsigned PW = $clog2(CODES),
  localparam int unsigned CW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODES-1:0]  tick_i,
  input  logic              ctl_we_i,
  input  logic              en_i,
  input  logic              rl_i,
  input  logic [PW-1:0]     pre_i,
  input  logic              os_i,
  input  logic              ivl_we_i,
  input  logic              ivh_we_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              cnl_rd_i,
  output logic              en_o,
  output logic              os_o,
  output logic [PW-1:0]     pre_o,
  output logic [CW-1:0]     ival_o,
  output logic [DATA_W-1:0] cnt_lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              expire_o
);
  localparam int unsigned SW = $clog2(DIS_DELAY + 2);

  logic              run_q, en_q, os_q, tick;
  logic [PW-1:0]     pre_q;
  logic [SW-1:0]     stop_q;
  logic [CW-1:0]     cnt_q, ival_q;
  logic [DATA_W-1:0] hi_q;

  assign tick     = tick_i[pre_q];
  assign expire_o = run_q & tick & (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      en_q   <= 1'b0;
      os_q   <= 1'b0;
      pre_q  <= '0;
      stop_q <= '0;
      cnt_q  <= '0;
      ival_q <= '0;
      hi_q   <= '0;
    end else begin
      if (run_q && tick) begin
        if (cnt_q == '0) begin
          if (os_q) run_q <= 1'b0;
          else      cnt_q <= ival_q;
        end else begin
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1) && os_q) begin
            run_q  <= 1'b0;
            en_q   <= 1'b0;
            stop_q <= '0;
          end
        end
      end
      // a pending disable runs out after DIS_DELAY edges
      if (stop_q != '0) begin
        stop_q <= stop_q - SW'(1);
        if (stop_q == SW'(1)) run_q <= 1'b0;
      end
      if (ivl_we_i) ival_q[DATA_W-1:0]  <= wd_i;
      if (ivh_we_i) ival_q[CW-1:DATA_W] <= wd_i;
      if (cnl_rd_i) hi_q <= cnt_q[CW-1:DATA_W];
      if (ctl_we_i) begin
        en_q  <= en_i;
        os_q  <= os_i;
        pre_q <= pre_i;
        if (en_i) begin
          run_q  <= 1'b1;
          stop_q <= '0;
          if (rl_i) cnt_q <= ival_q;
        end else if (run_q && stop_q == '0) begin
          if (DIS_DELAY == 0) run_q  <= 1'b0;
          else                stop_q <= SW'(DIS_DELAY);
        end
      end
    end
  end

  assign en_o     = en_q;
  assign os_o     = os_q;
  assign pre_o    = pre_q;
  assign ival_o   = ival_q;
  assign cnt_lo_o = cnt_q[DATA_W-1:0];
  assign hi_o     = hi_q;
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIS_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned CW = 2 * DATA_W;
  localparam int unsigned PW = $clog2(PRE_CODES);

  logic [PRE_CODES-1:0]             tick_v;
  logic [NUM_CH-1:0]                ien_q, ist_q, ist_clr, exp_v, en_v, os_v;
  logic [NUM_CH-1:0]                ctl_hit, ivl_hit, ivh_hit, cnl_hit, cnh_hit, ctl_we_v;
  logic [NUM_CH-1:0][PW-1:0]        pre_v;
  logic [NUM_CH-1:0][CW-1:0]        ival_v;
  logic [NUM_CH-1:0][DATA_W-1:0]    ivlo_v, cnt_v, hi_v;
  logic                             ien_hit, ist_hit, ist_wr;
  logic [DATA_W-1:0]                rd_nx;

  assign ien_hit = (bus_addr == ADDR_W'(OFF_IEN));
  assign ist_hit = (bus_addr == ADDR_W'(OFF_IST));
  assign ist_wr  = bus_wr & ist_hit;
  assign ist_clr = ist_wr ? bus_wdata[NUM_CH-1:0] : '0;

  mtimer_prescale #(.CODES(PRE_CODES)) pre_i (
    .clk(clk), .rst(rst), .tick_o(tick_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned BASE = c * CH_STRIDE;
    assign ctl_hit[c]  = (bus_addr == ADDR_W'(BASE + CH_CTL));
    assign ivl_hit[c]  = (bus_addr == ADDR_W'(BASE + CH_IVL));
    assign ivh_hit[c]  = (bus_addr == ADDR_W'(BASE + CH_IVH));
    assign cnl_hit[c]  = (bus_addr == ADDR_W'(BASE + CH_CNL));
    assign cnh_hit[c]  = (bus_addr == ADDR_W'(BASE + CH_CNH));
    assign ctl_we_v[c] = bus_wr & ctl_hit[c];
    assign ivlo_v[c]   = ival_v[c][DATA_W-1:0];

    mtimer_chan #(.DATA_W(DATA_W), .DIS_DELAY(DIS_DELAY), .CODES(PRE_CODES)) chan_i (
      .clk(clk), .rst(rst), .tick_i(tick_v),
      .ctl_we_i(ctl_we_v[c]),
      .en_i(bus_wdata[CTL_EN]), .rl_i(bus_wdata[CTL_RL]),
      .pre_i(bus_wdata[CTL_PRE_LSB +: PW]), .os_i(bus_wdata[CTL_OS]),
      .ivl_we_i(bus_wr & ivl_hit[c]), .ivh_we_i(bus_wr & ivh_hit[c]),
      .wd_i(bus_wdata), .cnl_rd_i(bus_rd & cnl_hit[c]),
      .en_o(en_v[c]), .os_o(os_v[c]), .pre_o(pre_v[c]),
      .ival_o(ival_v[c]), .cnt_lo_o(cnt_v[c]), .hi_o(hi_v[c]),
      .expire_o(exp_v[c])
    );
  end

  always_comb begin
    rd_nx = '0;
    if (ien_hit) rd_nx[NUM_CH-1:0] = ien_q;
    if (ist_hit) rd_nx[NUM_CH-1:0] = ist_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ctl_hit[c]) begin
        rd_nx[CTL_EN]              = en_v[c];
        rd_nx[CTL_OS]              = os_v[c];
        rd_nx[CTL_PRE_LSB +: PW]   = pre_v[c];
      end
      if (ivl_hit[c]) rd_nx = ival_v[c][DATA_W-1:0];
      if (ivh_hit[c]) rd_nx = ival_v[c][CW-1:DATA_W];
      if (cnl_hit[c]) rd_nx = cnt_v[c];
      if (cnh_hit[c]) rd_nx = hi_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      ist_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && ien_hit) ien_q <= bus_wdata[NUM_CH-1:0];
      ist_q     <= (ist_q & ~ist_clr) | exp_v;
      irq       <= |(ist_q & ien_q);
      bus_rdata <= bus_rd ? rd_nx : '0;
    end
  end
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_rd,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic                          irq,
  input logic [NUM_CH-1:0]             ien_q,
  input logic [NUM_CH-1:0]             ist_q,
  input logic                          ist_wr,
  input logic [NUM_CH-1:0]             exp_v,
  input logic [NUM_CH-1:0]             os_v,
  input logic [NUM_CH-1:0]             en_v,
  input logic [NUM_CH-1:0]             ctl_we_v,
  input logic                          wd_en,
  input logic                          wd_rl,
  input logic [NUM_CH-1:0][DATA_W-1:0] ivlo_v,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_v
);
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (|(ist_q & ien_q)) |=> irq);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(ist_q & ien_q)) |=> !irq);
  p_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
  p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ist_wr |=> ((ist_q & $past(ist_q)) == $past(ist_q)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_expire_flag_r5: assert property (@(posedge clk) disable iff (rst)
      exp_v[c] |=> ist_q[c]);
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
      (exp_v[c] && os_v[c] && !ctl_we_v[c]) |=> !en_v[c]);
    p_reload_load_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl_we_v[c] && wd_en && wd_rl) |=> (cnt_v[c] == $past(ivlo_v[c])));
  end
endmodule

bind mtimer_top mtimer_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
  .ien_q(ien_q), .ist_q(ist_q), .ist_wr(ist_wr), .exp_v(exp_v),
  .os_v(os_v), .en_v(en_v), .ctl_we_v(ctl_we_v),
  .wd_en(bus_wdata[0]), .wd_rl(bus_wdata[1]),
  .ivlo_v(ivlo_v), .cnt_v(cnt_v)
);

// File: tb/mtimer_top_tb_top.sv
`timescale 1ns/1ps
module mtimer_top_tb_top;
  localparam int NCH = 3;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int DD  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  mtimer_top #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW), .DIS_DELAY(DD)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] ra(int ch, int off);
    return AW'(ch * 32 + off);
  endfunction

  function automatic logic [31:0] exp_cnt(int v, int j, bit os);
    if (os) return (j >= v) ? 32'd0 : 32'(v - j);
    return 32'(v - (j % (v + 1)));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    d = rdata; rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    brd(8'h00, d); chk("R1 ien", d, 0);
    brd(8'h04, d); chk("R1 status", d, 0);
    brd(ra(0, 'h10), d); chk("R1 ctl", d, 0);
    brd(ra(2, 'h1C), d); chk("R1 count", d, 0);

    // R2 unmapped offsets
    bwr(8'h08, 32'hFFFF_FFFF);
    brd(8'h08, d); chk("R2 unmapped 08", d, 0);
    bwr(ra(3, 'h10), 32'h83);
    brd(ra(3, 'h10), d); chk("R2 unmapped 70", d, 0);
    brd(8'h00, d); chk("R2 ien untouched", d, 0);
    bwr(8'h00, 32'hFF);
    brd(8'h00, d); chk("R2 ien width", d, 7);
    bwr(8'h00, 0);

    // R4 decrement, prescale 0 and 3
    bwr(ra(0, 'h14), 1000); bwr(ra(0, 'h18), 0);
    bwr(ra(0, 'h10), 32'h03);
    idle(20);
    brd(ra(0, 'h1C), d); chk("R4 pre0", d, 980);
    bwr(ra(1, 'h14), 1000);
    bwr(ra(1, 'h10), 32'h33);
    idle(80);
    brd(ra(1, 'h1C), d); chk("R4 pre3", d, 990);
    brd(ra(1, 'h10), d); chk("R3 readback", d, 32'h31);
    bwr(ra(1, 'h10), 0);

    // R7 disable delay
    bwr(ra(0, 'h10), 32'h03);
    bwr(ra(0, 'h10), 32'h00);
    idle(5);
    brd(ra(0, 'h1C), d); chk("R7 frozen", d, 1000 - 1 - DD);
    idle(5);
    brd(ra(0, 'h1C), d); chk("R7 held", d, 1000 - 1 - DD);

    // R6 / R5 / R9 / R8 one-shot on channel 2
    bwr(8'h00, 4);
    bwr(ra(2, 'h14), 5);
    bwr(ra(2, 'h10), 32'h83);
    idle(4);
    brd(8'h04, d); chk("R5 not yet", d & 4, 0);
    brd(8'h04, d); chk("R5 set", d & 4, 4);
    chk("R9 irq high", irq, 1);
    brd(ra(2, 'h10), d); chk("R6 en cleared", d, 32'h80);
    brd(ra(2, 'h1C), d); chk("R6 count zero", d, 0);
    idle(3);
    brd(ra(2, 'h1C), d); chk("R6 stays zero", d, 0);
    bwr(8'h04, 0);
    brd(8'h04, d); chk("R8 zero write", d & 4, 4);
    bwr(8'h04, 4);
    chk("R9 irq latency", irq, 1);
    idle(1);
    chk("R9 irq low", irq, 0);
    brd(8'h04, d); chk("R8 cleared", d & 4, 0);
    bwr(8'h00, 0);

    // R5 periodic reload
    bwr(ra(0, 'h14), 3);
    bwr(ra(0, 'h10), 32'h03);
    idle(3);
    brd(ra(0, 'h1C), d); chk("R5 reach zero", d, 0);
    brd(ra(0, 'h1C), d); chk("R5 reload", d, 3);
    brd(8'h04, d); chk("R5 status ch0", d & 1, 1);
    bwr(ra(0, 'h10), 0);

    // R10 split read across the 32-bit carry
    bwr(ra(1, 'h14), 5); bwr(ra(1, 'h18), 1);
    bwr(ra(1, 'h10), 32'h03);
    idle(4);
    brd(ra(1, 'h1C), d); chk("R10 low", d, 1);
    idle(3);
    brd(ra(1, 'h20), d); chk("R10 latched high", d, 1);
    brd(ra(1, 'h1C), d); chk("R10 low after carry", d, 32'hFFFF_FFFC);
    brd(ra(1, 'h20), d); chk("R10 new high", d, 0);
    bwr(ra(1, 'h10), 0); bwr(ra(1, 'h18), 0);

    // random runs
    for (int it = 0; it < 24; it++) begin
      int ch, v, pre, k, j;
      bit os;
      ch  = int'($urandom % NCH);
      v   = 1 + int'($urandom % 40);
      pre = int'($urandom % 3);
      os  = 1'($urandom % 2);
      k   = (1 + int'($urandom % 12)) << pre;
      j   = k >> pre;
      bwr(ra(ch, 'h14), 32'(v));
      bwr(ra(ch, 'h10), (32'(os) << 7) | (32'(pre) << 4) | 32'h3);
      bwr(8'h04, 32'(1 << ch));
      idle(k - 1);
      brd(ra(ch, 'h1C), d);
      chk($sformatf("R4 R5 rand it%0d", it), d, exp_cnt(v, j, os));
      if (pre == 0) begin
        brd(8'h04, d);
        chk($sformatf("R5 rand status it%0d", it), (d >> ch) & 1, (j + 1 >= v) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule